// File: doc/BRIEF.md
# State-Gated LED Blink Generator

This block drives a six-bit LED bank from the current state of a small control state machine. The output depends on the state alone. Three states each show a fixed pattern. One state makes the LEDs alternate between two patterns. Any state code with no meaning turns every LED off. The state machine's own transitions live elsewhere: this block only watches the state code and the button pair that ends the blinking state.

The alternation comes from a phase bit and a cycle counter. While the blinking state is present, the counter runs up to the limit of the current phase. At that limit it wraps to zero and flips the phase. The two phase lengths are set apart from each other: one full on-plus-off period equals one second of clock cycles, and a percentage sets how much of it is the "high" share. When exactly one of the two buttons is seen while blinking, the counter and phase are forced to zero. The next visit therefore always starts with a complete low phase. In all other states the counter and phase hold still.

The reset input clears the counter and phase at once when it is asserted. Its release reaches the logic through a two-stage synchroniser.

Top module: `led_blink_gen`

## Requirements
- R1: State code 0 shows 6'b111111, state code 2 shows 6'b100010 and state code 3 shows 6'b110110, whatever the phase.
- R2: State codes 4 to 7 drive 6'b000000.
- R3: In state code 1 the LEDs show 6'b010100 while the phase is high and the parameter LED_ALT while the phase is low. After reset the phase is low.
- R4: With HIGH_CYC = CLK_HZ*HIGH_PCT/100 and LOW_CYC = CLK_HZ - HIGH_CYC, each low phase lasts LOW_CYC clock cycles and each high phase lasts HIGH_CYC cycles while state 1 is held. The two together make a period of CLK_HZ cycles.
- R5: If the state is 1 and btn is 2'b01 or 2'b10 at a clock edge, the counter and phase become zero. A later stay in state 1 then starts with a full low phase.
- R6: btn values 2'b00 and 2'b11 have no effect in state 1. In every other state, btn has no effect at all.
- R7: Outside state 1 the counter and phase hold. A return to state 1 without an exit press resumes the interrupted phase where it stopped.
- R8: Driving rst_n low clears the counter and phase at once, without waiting for a clock edge. The counter starts advancing again on the third rising edge after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| fsm_state | input | 3 | Current state code of the observed state machine |
| btn | input | 2 | Button pair; exactly one pressed in state 1 is the exit condition |
| led | output | 6 | LED pattern |

## Verification
The bench shortens the period to 20 cycles with a 30 % high share. This makes the low and high phases 14 and 6 cycles long, so a design that swapped the two limits, or miscounted a limit by one, falls out of step with the reference within one period. The bench presses each single button in the middle of a phase. A design that cleared only the counter, or only the phase, would then show a short or inverted first phase on the next visit. The bench also leaves state 1 and comes back through other states. A design that kept counting, or cleared on leaving, would resume at the wrong point. Finally, the bench asserts reset between clock edges and checks the LEDs before the next edge, which catches a reset that only acts on the clock.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int STATE_W = 3;
  localparam int LED_W   = 6;

  localparam logic [STATE_W-1:0] ST_ALL_ON = 3'd0;
  localparam logic [STATE_W-1:0] ST_BLINK  = 3'd1;
  localparam logic [STATE_W-1:0] ST_PAIR   = 3'd2;
  localparam logic [STATE_W-1:0] ST_QUAD   = 3'd3;

  localparam logic [LED_W-1:0] PAT_ALL_ON = 6'b111111;
  localparam logic [LED_W-1:0] PAT_BLINK  = 6'b010100;
  localparam logic [LED_W-1:0] PAT_PAIR   = 6'b100010;
  localparam logic [LED_W-1:0] PAT_QUAD   = 6'b110110;
  localparam logic [LED_W-1:0] PAT_DARK   = 6'b000000;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/blink_rst_sync.sv
module blink_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/blink_phase_timer.sv
module blink_phase_timer
  import led_blink_pkg::*;
#(
  parameter int HIGH_MAX = 7,
  parameter int LOW_MAX  = 7
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active,
  input  logic   clear,
  output phase_e phase
);
  localparam int MAX_LIM = (HIGH_MAX > LOW_MAX) ? HIGH_MAX : LOW_MAX;
  localparam int CNT_W   = (MAX_LIM < 1) ? 1 : $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HIGH_MAX);
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(LOW_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           phase_q, phase_d;
  logic             cnt_en;
  logic [CNT_W-1:0] lim;
  logic             at_lim;

  assign lim    = (phase_q == PH_HIGH) ? HI_LIM : LO_LIM;
  assign at_lim = (cnt_q == lim);
  assign cnt_en = active | clear;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (clear) begin
      cnt_d   = '0;
      phase_d = PH_LOW;
    end else if (active) begin
      if (at_lim) begin
        cnt_d   = '0;
        phase_d = (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  p_wrap_toggles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clear && at_lim) |=> (cnt_q == '0) && (phase_q != $past(phase_q)));

  p_exit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && (phase_q == PH_LOW));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable(cnt_q) && $stable(phase_q));
endmodule

// File: rtl/led_pattern_decode.sv
module led_pattern_decode
  import led_blink_pkg::*;
#(
  parameter logic [LED_W-1:0] LED_ALT = 6'b001000
) (
  input  logic [STATE_W-1:0] fsm_state,
  input  phase_e             phase,
  output logic [LED_W-1:0]   led
);
  always_comb begin
    unique case (fsm_state)
      ST_ALL_ON: led = PAT_ALL_ON;
      ST_BLINK:  led = (phase == PH_HIGH) ? PAT_BLINK : LED_ALT;
      ST_PAIR:   led = PAT_PAIR;
      ST_QUAD:   led = PAT_QUAD;
      default:   led = PAT_DARK;
    endcase
  end
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
  import led_blink_pkg::*;
#(
  parameter int               CLK_HZ   = 125_000_000,
  parameter int               HIGH_PCT = 50,
  parameter logic [5:0]       LED_ALT  = 6'b001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fsm_state,
  input  logic [1:0] btn,
  output logic [5:0] led
);
  localparam longint HIGH_CYC = (longint'(CLK_HZ) * longint'(HIGH_PCT)) / 100;
  localparam longint LOW_CYC  = longint'(CLK_HZ) - HIGH_CYC;
  localparam int     HIGH_MAX = int'(HIGH_CYC) - 1;
  localparam int     LOW_MAX  = int'(LOW_CYC) - 1;

  logic   rst_sync_n;
  logic   in_blink;
  logic   exit_press;
  phase_e phase;

  assign in_blink   = (fsm_state == ST_BLINK);
  assign exit_press = in_blink && (btn == 2'b01 || btn == 2'b10);

  blink_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  blink_phase_timer #(
    .HIGH_MAX (HIGH_MAX),
    .LOW_MAX  (LOW_MAX)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .active (in_blink),
    .clear  (exit_press),
    .phase  (phase)
  );

  led_pattern_decode #(
    .LED_ALT (LED_ALT)
  ) u_decode (
    .fsm_state (fsm_state),
    .phase     (phase),
    .led       (led)
  );

  p_phase_frozen_outside_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_blink |=> $stable(phase));

  p_blink_pair_only_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_blink |-> (led == PAT_BLINK || led == LED_ALT));
endmodule

// File: tb/led_blink_gen_bench.sv
module led_blink_gen_bench;
  localparam int         CLK_HZ   = 20;
  localparam int         HIGH_PCT = 30;
  localparam logic [5:0] ALT      = 6'b001000;
  localparam int         H_LEN    = CLK_HZ * HIGH_PCT / 100;
  localparam int         L_LEN    = CLK_HZ - H_LEN;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] fsm_state;
  logic [1:0] btn;
  logic [5:0] led;

  int n_cmp = 0;
  int n_bad = 0;
  int m_cnt, m_sel, m_rs;
  int wd = 0;
  string tag = "R8";

  always #4 clk = ~clk;

  led_blink_gen #(.CLK_HZ(CLK_HZ), .HIGH_PCT(HIGH_PCT), .LED_ALT(ALT)) u_led_blink_gen (
    .clk(clk), .rst_n(rst_n), .fsm_state(fsm_state), .btn(btn), .led(led)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_rs = 0;
    end else if (m_rs < 2) begin
      m_rs = m_rs + 1;
    end else if (fsm_state == 3'd1) begin
      if (btn == 2'b01 || btn == 2'b10) begin
        m_cnt = 0; m_sel = 0;
      end else if (m_cnt == (m_sel ? H_LEN - 1 : L_LEN - 1)) begin
        m_cnt = 0; m_sel = 1 - m_sel;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  function automatic logic [5:0] exp_led(input logic [2:0] s, input int sel);
    case (s)
      3'd0: return 6'b111111;
      3'd1: return sel ? 6'b010100 : ALT;
      3'd2: return 6'b100010;
      3'd3: return 6'b110110;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check(input string rq);
    logic [5:0] e;
    e = exp_led(fsm_state, m_sel);
    n_cmp++;
    if (led !== e) begin
      n_bad++;
      $display("FAIL %s: led=%b expected=%b t=%0t", rq, led, e, $time);
    end
  endtask

  task automatic run(input logic [2:0] s, input logic [1:0] b, input int n, input string rq);
    fsm_state = s; btn = b; tag = rq;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", wd, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fsm_state = 3'd0; btn = 2'b00;
    run(3'd1, 2'b00, 3, "R8");
    run(3'd0, 2'b00, 2, "R8");
    rst_n = 1'b1;
    run(3'd0, 2'b00, 4, "R1");
    run(3'd2, 2'b01, 3, "R1");
    run(3'd3, 2'b10, 3, "R1");
    for (int s = 4; s < 8; s++) run(3'(s), 2'b00, 2, "R2");
    run(3'd1, 2'b00, 45, "R4");
    run(3'd1, 2'b11, 10, "R6");
    run(3'd1, 2'b00, 8, "R3");
    run(3'd0, 2'b01, 5, "R6");
    run(3'd5, 2'b10, 3, "R6");
    run(3'd1, 2'b00, 9, "R7");
    run(3'd2, 2'b00, 7, "R7");
    run(3'd1, 2'b00, 20, "R7");
    run(3'd1, 2'b01, 1, "R5");
    run(3'd0, 2'b00, 3, "R5");
    run(3'd1, 2'b00, 17, "R5");
    run(3'd1, 2'b10, 1, "R5");
    run(3'd1, 2'b00, 25, "R5");
    run(3'd1, 2'b00, 16, "R8");
    #3;
    rst_n = 1'b0;
    #1;
    n_cmp++;
    if (led !== ALT) begin
      n_bad++;
      $display("FAIL R8: led=%b expected=%b (async clear)", led, ALT);
    end
    run(3'd1, 2'b00, 2, "R8");
    rst_n = 1'b1;
    run(3'd1, 2'b00, 24, "R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule